// File: doc/BRIEF.md
# Log-Depth Multiplexer Chain Evaluator

This block works out, in one pass, the output of every stage in a chain of N two-input multiplexers. In the chain, each stage's select input is driven by the output of the stage before it. The first stage takes its select from a primary input. Each stage has two data inputs. A stage drives its `b` input when its select is 1 and its `a` input when its select is 0. Evaluated directly, the chain ripples through N mux delays.

The block avoids that ripple. It notes that the data pair fixes what a stage does to its select, and there are only four possibilities: force 0, force 1, pass the select through, or pass its complement. Each stage is reduced to one of these four transforms. The transforms are merged by an associative rule in a tree of ceil(log2 N) levels, which produces the combined transform for every prefix of the chain. Each prefix transform is then applied to the primary select.

The data vectors and the select are captured in registers. All N stage outputs leave through a register. The results of an input set therefore appear on the second rising clock edge after it is presented.

Top module: `mux_chain_prefix`

## Requirements
- R1: While `rst_n` is low, `stage_out` is all zero. It stays zero until the first input set captured after reset reaches the output.
- R2: A stage with `a=0, b=0` outputs 0 whatever its incoming select is.
- R3: A stage with `a=1, b=1` outputs 1 whatever its incoming select is.
- R4: A stage with `a=0, b=1` outputs its incoming select unchanged. For stage k>0 the incoming select is `stage_out[k-1]`.
- R5: A stage with `a=1, b=0` outputs the complement of its incoming select.
- R6: Stage 0 takes `sel_in` as its incoming select.
- R7: For any inputs, bit k of `stage_out` equals the value obtained by evaluating the chain one stage at a time from stage 0 to stage k.
- R8: Inputs sampled on a rising edge appear on `stage_out` after the following rising edge. The edge in between leaves the previous result unchanged.
- R9: After a stage that forces 0 or forces 1, that stage's output and every later stage output are independent of `sel_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | N | Per-stage data input chosen when the stage select is 0 |
| b_in | input | N | Per-stage data input chosen when the stage select is 1 |
| sel_in | input | 1 | Select fed to stage 0 |
| stage_out | output | N | Output of every stage, bit k for stage k |

## Verification
The hardest situation to reach from the ports is a long run of invert and pass stages. In such a run, the merged transform depends on the parity of inverts across many tree levels before it reaches a stage far down the chain. Random data rarely forms such runs past a few stages. The stimulus therefore sweeps every combination of the four transforms over the first five stages, with both select values, and fills the remaining stages at random. Every merge the tree can perform at its lowest levels is thus met with each possible earlier transform. A directed pair of vectors that differ only in `sel_in` shows that everything after a forcing stage ignores the select.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

    // Per-stage transform applied to the incoming select
    typedef enum logic [1:0] {
        XF_ZERO = 2'b00,   // output forced to 0
        XF_ONE  = 2'b01,   // output forced to 1
        XF_PASS = 2'b10,   // output follows select
        XF_FLIP = 2'b11    // output is complement of select
    } xform_e;

    function automatic xform_e xf_from_data(input logic a, input logic b);
        xform_e r;
        unique case ({a, b})
            2'b00:   r = XF_ZERO;
            2'b11:   r = XF_ONE;
            2'b01:   r = XF_PASS;
            default: r = XF_FLIP;
        endcase
        return r;
    endfunction

    // Merge an earlier span with a later span into one transform
    function automatic xform_e xf_merge(input xform_e early, input xform_e late);
        logic [1:0] e;
        xform_e r;
        e = early;
        unique case (late)
            XF_ZERO: r = XF_ZERO;
            XF_ONE:  r = XF_ONE;
            XF_PASS: r = early;
            default: r = xform_e'({e[1], ~e[0]});
        endcase
        return r;
    endfunction

    function automatic logic xf_eval(input xform_e x, input logic s);
        logic [1:0] v;
        v = x;
        return v[1] ? (s ^ v[0]) : v[0];
    endfunction

endpackage

// File: rtl/mcp_encode.sv
module mcp_encode
    import mcp_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output xform_e       xf_o [N]
);

    for (genvar k = 0; k < N; k++) begin : g_stage
        assign xf_o[k] = xf_from_data(a_i[k], b_i[k]);
    end

endmodule

// File: rtl/mcp_prefix_tree.sv
module mcp_prefix_tree
    import mcp_pkg::*;
#(
    parameter int N = 16
) (
    input  xform_e xf_i [N],
    output xform_e pf_o [N]
);

    localparam int LEVELS = (N > 1) ? $clog2(N) : 1;

    xform_e cur [N];
    xform_e nxt [N];

    // Kogge-Stone: at level l each position merges with the one 2**l below
    always_comb begin
        cur = xf_i;
        nxt = xf_i;
        for (int l = 0; l < LEVELS; l++) begin
            for (int i = 0; i < N; i++) begin
                if (i >= (1 << l)) begin
                    nxt[i] = xf_merge(cur[i - (1 << l)], cur[i]);
                end else begin
                    nxt[i] = cur[i];
                end
            end
            cur = nxt;
        end
        pf_o = cur;
    end

endmodule

// File: rtl/mcp_apply.sv
module mcp_apply
    import mcp_pkg::*;
#(
    parameter int N = 16
) (
    input  xform_e       pf_i [N],
    input  logic         sel_i,
    output logic [N-1:0] out_o
);

    for (genvar k = 0; k < N; k++) begin : g_out
        assign out_o[k] = xf_eval(pf_i[k], sel_i);
    end

endmodule

// File: rtl/mux_chain_prefix.sv
module mux_chain_prefix
    import mcp_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    input  logic         sel_in,
    output logic [N-1:0] stage_out
);

    logic [N-1:0] a_q;
    logic [N-1:0] b_q;
    logic         sel_q;
    logic [N-1:0] res_d;

    xform_e stage_xf  [N];
    xform_e prefix_xf [N];

    // Input capture: reset value a=b=0 makes every stage force 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            sel_q <= 1'b0;
        end else begin
            a_q   <= a_in;
            b_q   <= b_in;
            sel_q <= sel_in;
        end
    end

    mcp_encode #(.N(N)) enc_i (
        .a_i  (a_q),
        .b_i  (b_q),
        .xf_o (stage_xf)
    );

    mcp_prefix_tree #(.N(N)) tree_i (
        .xf_i (stage_xf),
        .pf_o (prefix_xf)
    );

    mcp_apply #(.N(N)) apply_i (
        .pf_i  (prefix_xf),
        .sel_i (sel_q),
        .out_o (res_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_out <= '0;
        end else begin
            stage_out <= res_d;
        end
    end

endmodule

// File: rtl/mux_chain_prefix_checker.sv
module mux_chain_prefix_checker #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] a_in,
    input logic [N-1:0] b_in,
    input logic         sel_in,
    input logic [N-1:0] stage_out
);

    // Edges seen since reset; two are needed before $past(...,2) is meaningful
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end
    wire ready = (warm == 2'd2);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> stage_out == '0);

    a_r6_pass_from_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(a_in[0], 2) == 1'b0 && $past(b_in[0], 2) == 1'b1)
        |-> stage_out[0] == $past(sel_in, 2));

    a_r6_flip_from_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(a_in[0], 2) == 1'b1 && $past(b_in[0], 2) == 1'b0)
        |-> stage_out[0] != $past(sel_in, 2));

    for (genvar k = 0; k < N; k++) begin : g_chk
        a_r2_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && $past(a_in[k], 2) == 1'b0 && $past(b_in[k], 2) == 1'b0)
            |-> stage_out[k] == 1'b0);

        a_r3_force_one: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && $past(a_in[k], 2) == 1'b1 && $past(b_in[k], 2) == 1'b1)
            |-> stage_out[k] == 1'b1);

        if (k > 0) begin : g_link
            a_r4_pass_prev: assert property (@(posedge clk) disable iff (!rst_n)
                (ready && $past(a_in[k], 2) == 1'b0 && $past(b_in[k], 2) == 1'b1)
                |-> stage_out[k] == stage_out[k-1]);

            a_r5_flip_prev: assert property (@(posedge clk) disable iff (!rst_n)
                (ready && $past(a_in[k], 2) == 1'b1 && $past(b_in[k], 2) == 1'b0)
                |-> stage_out[k] != stage_out[k-1]);
        end
    end

endmodule

bind mux_chain_prefix mux_chain_prefix_checker #(.N(N)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .b_in      (b_in),
    .sel_in    (sel_in),
    .stage_out (stage_out)
);

// File: tb/mux_chain_prefix_tb_top.sv
module mux_chain_prefix_tb_top;

    localparam int N          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int SWEEP_ST   = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a_in = '0;
    logic [N-1:0] b_in = '0;
    logic         sel_in = 1'b0;
    logic [N-1:0] stage_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mux_chain_prefix #(.N(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_in      (a_in),
        .b_in      (b_in),
        .sel_in    (sel_in),
        .stage_out (stage_out)
    );

    // Sequential model: select 1 picks b, select 0 picks a
    function automatic logic [N-1:0] ripple(input logic [N-1:0] a,
                                            input logic [N-1:0] b,
                                            input logic s);
        logic [N-1:0] r;
        logic cur;
        cur = s;
        for (int k = 0; k < N; k++) begin
            cur  = cur ? b[k] : a[k];
            r[k] = cur;
        end
        return r;
    endfunction

    task automatic check_bits(input string tag, input logic [N-1:0] got,
                              input logic [N-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, sample two edges later at a falling edge
    task automatic run_vec(input logic [N-1:0] a, input logic [N-1:0] b,
                           input logic s, output logic [N-1:0] got);
        logic [N-1:0] exp;
        @(negedge clk);
        a_in = a; b_in = b; sel_in = s;
        @(negedge clk);
        @(negedge clk);
        got = stage_out;
        exp = ripple(a, b, s);
        check_bits("R7 whole chain", got, exp);
        for (int k = 0; k < N; k++) begin
            n_checks++;
            if (got[k] !== exp[k]) begin
                n_fail++;
                if (k == 0)
                    $display("FAIL R6 stage 0 (a=%b b=%b sel=%b): got %b expected %b",
                             a[0], b[0], s, got[0], exp[0]);
                else if (!a[k] && !b[k])
                    $display("FAIL R2 stage %0d: got %b expected %b", k, got[k], exp[k]);
                else if (a[k] && b[k])
                    $display("FAIL R3 stage %0d: got %b expected %b", k, got[k], exp[k]);
                else if (!a[k] && b[k])
                    $display("FAIL R4 stage %0d: got %b expected %b", k, got[k], exp[k]);
                else
                    $display("FAIL R5 stage %0d: got %b expected %b", k, got[k], exp[k]);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] got;
        logic [N-1:0] got0;
        logic [N-1:0] got1;
        logic [N-1:0] ra;
        logic [N-1:0] rb;

        // R1: reset state and first cycle after release
        repeat (3) @(negedge clk);
        check_bits("R1 during reset", stage_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bits("R1 after release", stage_out, '0);

        // R2..R7: every transform mix over the first stages, both selects
        for (int code = 0; code < (1 << (2 * SWEEP_ST)); code++) begin
            for (int s = 0; s < 2; s++) begin
                ra = N'($urandom);
                rb = N'($urandom);
                for (int k = 0; k < SWEEP_ST; k++) begin
                    ra[k] = code[2 * k];
                    rb[k] = code[2 * k + 1];
                end
                run_vec(ra, rb, s[0], got);
            end
        end

        // R7: fully random vectors
        for (int i = 0; i < 500; i++) begin
            run_vec(N'($urandom), N'($urandom), 1'($urandom), got);
        end

        // R7: long pass/flip runs with no forcing stage
        for (int i = 0; i < 200; i++) begin
            ra = N'($urandom);
            run_vec(ra, ~ra, 1'($urandom), got);
        end

        // R9: stage 3 forces 0; later outputs ignore the select
        for (int i = 0; i < 20; i++) begin
            ra = N'($urandom);
            rb = N'($urandom);
            ra[3] = 1'b0; rb[3] = 1'b0;
            run_vec(ra, rb, 1'b0, got0);
            run_vec(ra, rb, 1'b1, got1);
            check_bits("R9 after forcing stage", got1 >> 3, got0 >> 3);
        end
        // R9: stage 7 forces 1
        ra = N'($urandom);
        rb = N'($urandom);
        ra[7] = 1'b1; rb[7] = 1'b1;
        run_vec(ra, rb, 1'b0, got0);
        run_vec(ra, rb, 1'b1, got1);
        check_bits("R9 after forcing stage", got1 >> 7, got0 >> 7);

        // R8: latency, all-zero result then all-one result
        run_vec('0, '0, 1'b1, got);
        @(negedge clk);
        a_in = '1; b_in = '1; sel_in = 1'b0;
        @(negedge clk);
        check_bits("R8 one edge after change", stage_out, '0);
        @(negedge clk);
        check_bits("R8 two edges after change", stage_out, '1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule